// File: doc/BRIEF.md
# Three-Wire Configuration Register Port

This block holds the control settings of an image-sensor front end and lets a host write them over a three-wire port. The port has no readback. The host holds a load strobe low and sends a 16-bit word on a data pin, one bit per rising edge of a shift clock. It then raises the strobe. That rising edge decodes the word and updates a parallel latch of settings, which sits in the strobe's own timing domain.

The latched settings then move into working registers clocked by the sample clock. A toggle event passes through a two-flop synchroniser and then a short countdown. The outputs therefore change on the fifth or sixth sample-clock edge after the strobe rises. The working registers drive these outputs:

- a standby flag
- a converter drive-mode flag
- a 10-bit gain code
- a 4-bit black-level code
- three input-polarity bits
- a 2-bit output-delay code

An active-low reset clears every stage at once, with no clock needed. Words sent to unused addresses, and words with the test flag set, leave all settings unchanged.

Top module: `sctl_top`

## Requirements
- R1: The shift register takes the data pin on each rising edge of the shift clock while the load strobe is low. Shift-clock edges while the strobe is high leave the shift register unchanged.
- R2: Words go in MSB first. Bit 15 is the test flag, bits 14..12 are the address and bits 11..0 are data.
- R3: When more than 16 bits are clocked in before the strobe rises, only the last 16 bits form the word.
- R4: A word with the test flag clear is decoded on the rising strobe edge as follows:
  - Address 0: data bit 8 sets the drive-mode flag (1 = external) and data bit 0 sets standby (1 = standby).
  - Address 1: data bits 9..0 are the gain code.
  - Address 2: data bits 3..0 are the black-level code.
  - Address 3: data bits 2..0 are the polarity bits.
  - Address 4: data bits 1..0 are the output-delay code.
- R5: Writes to addresses 5, 6 and 7, and any word with the test flag set, change no setting. Data bits outside the field of a valid address are ignored.
- R6: While reset is low, and immediately with no clock, all outputs take these values: standby 0, drive mode 0, gain 128, black level 8, polarity 0, output delay 0.
- R7: When the strobe rises midway between sample-clock edges, the outputs keep their old values through the fourth following sample-clock rising edge. They show the new values from the fifth.
- R8: Writes are accepted and take effect while the standby output is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| smp_clk | input | 1 | Sample clock of the working registers |
| rst_n | input | 1 | Asynchronous reset, active low |
| sload | input | 1 | Load strobe; shifting while low, latch on rising edge |
| sclk | input | 1 | Shift clock |
| sdi | input | 1 | Serial data in |
| standby | output | 1 | 1 = standby mode |
| ext_drive | output | 1 | 1 = converter driven by external clock |
| gain | output | 10 | Gain code |
| blk_lvl | output | 4 | Black-level code |
| pol | output | 3 | Polarity bits |
| odly | output | 2 | Output-delay code |

## Verification
The bench walks a sequence of writes through every address. It includes reserved addresses and test-flag words, which a design with a loose address decode would apply as a gain or configuration change. It also sends data words carrying junk outside the defined field; a design that masks fields wrongly would let this junk leak into an output.

Directed cases cover three more faults:
- A 20-bit burst, which a design keeping the first 16 bits would decode as a test word.
- Shift-clock pulses with the strobe high, which a design shifting on every clock edge would turn into a new gain.
- A mid-run reset, which a synchronous-only reset would fail to clear before the next clock.

The timing check samples after the fourth and fifth sample-clock edges following the strobe. A missing synchroniser stage or a wrong countdown length shows up as a value that arrives early or late.

// File: rtl/sctl_pkg.sv
package sctl_pkg;
  localparam int WORD_W  = 16;
  localparam int ADDR_W  = 3;
  localparam int DATA_W  = 12;
  localparam int GAIN_W  = 10;
  localparam int BLK_W   = 4;
  localparam int POL_W   = 3;
  localparam int DLY_W   = 2;
  localparam int EXT_BIT = 8;
  localparam int STBY_BIT = 0;

  localparam logic [ADDR_W-1:0] ADR_CFG  = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_GAIN = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_BLK  = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_POL  = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_DLY  = 3'd4;

  typedef struct packed {
    logic              stby;
    logic              ext;
    logic [GAIN_W-1:0] gain;
    logic [BLK_W-1:0]  blk;
    logic [POL_W-1:0]  pol;
    logic [DLY_W-1:0]  dly;
  } cfg_t;

  localparam cfg_t CFG_RST = '{stby: 1'b0, ext: 1'b0, gain: 10'd128,
                               blk: 4'b1000, pol: 3'b000, dly: 2'b00};
endpackage

// File: rtl/sctl_shift.sv
module sctl_shift #(
  parameter int W = 16
) (
  input  logic         sclk,
  input  logic         rst_n,
  input  logic         sload,
  input  logic         sdi,
  output logic [W-1:0] word
);
  logic prim_q;

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      word   <= '0;
      prim_q <= 1'b0;
    end else begin
      prim_q <= 1'b1;
      if (!sload) word <= {word[W-2:0], sdi};
    end
  end

  AST_SHIFT_CAPTURE: assert property (@(posedge sclk) disable iff (!rst_n)
    (prim_q && !$past(sload)) |-> (word[0] == $past(sdi))); // R1

  AST_SHIFT_HOLD: assert property (@(posedge sclk) disable iff (!rst_n)
    (prim_q && $past(sload)) |-> (word == $past(word))); // R1
endmodule

// File: rtl/sctl_latch.sv
module sctl_latch
  import sctl_pkg::*;
(
  input  logic              sload,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] word,
  output cfg_t              lat_q,
  output logic              evt_q
);
  logic              tflag;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] dat;
  logic              rsvd;
  logic              seen_q;
  cfg_t              nxt;

  assign tflag = word[WORD_W-1];
  assign addr  = word[WORD_W-2 -: ADDR_W];
  assign dat   = word[DATA_W-1:0];
  assign rsvd  = tflag || (addr > ADR_DLY);

  always_comb begin
    nxt = lat_q;
    if (!tflag) begin
      case (addr)
        ADR_CFG: begin
          nxt.ext  = dat[EXT_BIT];
          nxt.stby = dat[STBY_BIT];
        end
        ADR_GAIN: nxt.gain = dat[GAIN_W-1:0];
        ADR_BLK:  nxt.blk  = dat[BLK_W-1:0];
        ADR_POL:  nxt.pol  = dat[POL_W-1:0];
        ADR_DLY:  nxt.dly  = dat[DLY_W-1:0];
        default:  nxt = lat_q;
      endcase
    end
  end

  always_ff @(posedge sload or negedge rst_n) begin
    if (!rst_n) begin
      lat_q  <= CFG_RST;
      evt_q  <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      lat_q  <= nxt;
      evt_q  <= ~evt_q;
      seen_q <= 1'b1;
    end
  end

  AST_RESERVED_HOLD: assert property (@(posedge sload) disable iff (!rst_n)
    (seen_q && $past(rsvd)) |-> (lat_q == $past(lat_q))); // R5

  AST_CFG_WRITE: assert property (@(posedge sload) disable iff (!rst_n)
    (seen_q && $past(!tflag && addr == ADR_CFG)) |-> (lat_q.ext == $past(word[EXT_BIT]))); // R4
endmodule

// File: rtl/sctl_xfer.sv
module sctl_xfer
  import sctl_pkg::*;
#(
  parameter int XFER_WAIT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  cfg_t lat,
  output cfg_t work_q
);
  localparam int CW = $clog2(XFER_WAIT + 1);
  localparam logic [CW-1:0] WAIT_V = CW'(XFER_WAIT);

  logic          s1_q, s2_q, s3_q;
  logic          pulse;
  logic [CW-1:0] cnt_q;

  assign pulse = s2_q ^ s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      s3_q   <= 1'b0;
      cnt_q  <= '0;
      work_q <= CFG_RST;
    end else begin
      s1_q <= evt;
      s2_q <= s1_q;
      s3_q <= s2_q;
      if (pulse)            cnt_q <= WAIT_V;
      else if (cnt_q != '0) cnt_q <= cnt_q - CW'(1);
      if (cnt_q == CW'(1))  work_q <= lat;
    end
  end

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0) |=> $stable(work_q)); // R7

  AST_SYNC_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_q != s3_q) |=> (cnt_q == WAIT_V)); // R7
endmodule

// File: rtl/sctl_top.sv
module sctl_top
  import sctl_pkg::*;
#(
  parameter int XFER_WAIT = 2
) (
  input  logic              smp_clk,
  input  logic              rst_n,
  input  logic              sload,
  input  logic              sclk,
  input  logic              sdi,
  output logic              standby,
  output logic              ext_drive,
  output logic [GAIN_W-1:0] gain,
  output logic [BLK_W-1:0]  blk_lvl,
  output logic [POL_W-1:0]  pol,
  output logic [DLY_W-1:0]  odly
);
  logic [WORD_W-1:0] word;
  cfg_t              lat;
  logic              evt;
  cfg_t              work;

  sctl_shift #(.W(WORD_W)) u_shift (
    .sclk(sclk), .rst_n(rst_n), .sload(sload), .sdi(sdi), .word(word)
  );

  sctl_latch u_latch (
    .sload(sload), .rst_n(rst_n), .word(word), .lat_q(lat), .evt_q(evt)
  );

  sctl_xfer #(.XFER_WAIT(XFER_WAIT)) u_xfer (
    .clk(smp_clk), .rst_n(rst_n), .evt(evt), .lat(lat), .work_q(work)
  );

  assign standby   = work.stby;
  assign ext_drive = work.ext;
  assign gain      = work.gain;
  assign blk_lvl   = work.blk;
  assign pol       = work.pol;
  assign odly      = work.dly;
endmodule

// File: tb/sctl_top_test.sv
module sctl_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 12;
  localparam logic [20:0] DFLT = {1'b0, 1'b0, 10'd128, 4'h8, 3'd0, 2'd0};

  // entry: {word, expected {standby, ext_drive, gain, blk_lvl, pol, odly}}
  localparam logic [36:0] VEC [NV] = '{
    {16'h13FF, 1'b0, 1'b0, 10'h3FF, 4'h8, 3'd0, 2'd0},
    {16'h0101, 1'b1, 1'b1, 10'h3FF, 4'h8, 3'd0, 2'd0},
    {16'h2FF5, 1'b1, 1'b1, 10'h3FF, 4'h5, 3'd0, 2'd0},
    {16'h3FF5, 1'b1, 1'b1, 10'h3FF, 4'h5, 3'd5, 2'd0},
    {16'h4FFF, 1'b1, 1'b1, 10'h3FF, 4'h5, 3'd5, 2'd3},
    {16'h5123, 1'b1, 1'b1, 10'h3FF, 4'h5, 3'd5, 2'd3},
    {16'h9000, 1'b1, 1'b1, 10'h3FF, 4'h5, 3'd5, 2'd3},
    {16'h1000, 1'b1, 1'b1, 10'h000, 4'h5, 3'd5, 2'd3},
    {16'h0000, 1'b0, 1'b0, 10'h000, 4'h5, 3'd5, 2'd3},
    {16'h7FFF, 1'b0, 1'b0, 10'h000, 4'h5, 3'd5, 2'd3},
    {16'h0FFF, 1'b1, 1'b1, 10'h000, 4'h5, 3'd5, 2'd3},
    {16'h1080, 1'b1, 1'b1, 10'h080, 4'h5, 3'd5, 2'd3}
  };

  logic clk = 1'b0;
  logic rst_n, sload, sclk, sdi;
  logic standby, ext_drive;
  logic [9:0] gain;
  logic [3:0] blk_lvl;
  logic [2:0] pol;
  logic [1:0] odly;
  int n_chk = 0;
  int n_bad = 0;
  logic [20:0] exp_st;

  always #(CLK_PERIOD/2) clk = ~clk;

  sctl_top uut (
    .smp_clk(clk), .rst_n(rst_n), .sload(sload), .sclk(sclk), .sdi(sdi),
    .standby(standby), .ext_drive(ext_drive), .gain(gain),
    .blk_lvl(blk_lvl), .pol(pol), .odly(odly)
  );

  function automatic logic [20:0] outs();
    return {standby, ext_drive, gain, blk_lvl, pol, odly};
  endfunction

  task automatic check(input string tag, input logic [20:0] exp);
    n_chk++;
    if (outs() !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, outs(), exp);
    end
  endtask

  // shifts n bits MSB first, then raises the strobe at a sample-clock falling edge
  task automatic send(input logic [31:0] bits, input int n);
    sload = 1'b0;
    #3;
    for (int i = n - 1; i >= 0; i--) begin
      sdi = bits[i];
      #2 sclk = 1'b1;
      #2 sclk = 1'b0;
    end
    #2;
    @(negedge clk);
    sload = 1'b1;
  endtask

  function automatic string vtag(input int i);
    if (i == 5 || i == 6 || i == 9) return "R2/R5 vector";
    if (i == 7) return "R8 vector";
    return "R2/R4 vector";
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sload = 1'b1; sclk = 1'b0; sdi = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R6 reset defaults", DFLT);

    for (int i = 0; i < NV; i++) begin
      send({16'h0, VEC[i][36:21]}, 16);
      repeat (8) @(negedge clk);
      check(vtag(i), VEC[i][20:0]);
    end

    // R3: 20 bits, first four would form a test-flag word if kept
    send({12'h0, 4'hF, 16'h2003}, 20);
    repeat (8) @(negedge clk);
    exp_st = {1'b1, 1'b1, 10'h080, 4'h3, 3'd5, 2'd3};
    check("R3 overlong burst", exp_st);

    // R1: shift clocks with strobe high must not move the shift register
    for (int i = 15; i >= 0; i--) begin
      sdi = logic'(16'h1155 >> i);
      #2 sclk = 1'b1;
      #2 sclk = 1'b0;
    end
    sload = 1'b0;
    #3;
    @(negedge clk);
    sload = 1'b1;
    repeat (8) @(negedge clk);
    check("R1 clocks ignored while strobe high", exp_st);

    // R7: update lands on the fifth edge, not before
    send({16'h0, 16'h12AA}, 16);
    repeat (4) @(negedge clk);
    check("R7 still old after four edges", exp_st);
    @(negedge clk);
    exp_st = {1'b1, 1'b1, 10'h2AA, 4'h3, 3'd5, 2'd3};
    check("R7 new after five edges", exp_st);

    // R6: asynchronous reset clears outputs with no clock edge
    @(negedge clk);
    #1 rst_n = 1'b0;
    #1 check("R6 async reset", DFLT);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R6 after reset release", DFLT);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule